// File: doc/BRIEF.md
# Protected System Clock Control Register

This block holds an 8-bit clock control register and the system clock prescaler that it drives. Software writes the register over a simple strobe-and-data bus. A write takes effect only while a separate protect-enable input is high. Some fields are not under software control alone. The low-speed oscillator stop bit follows the oscillator-select input. A count-source-protect mode freezes the stop and low-speed-oscillator bits. Entering stop mode from a fast operating mode forces high crystal drive.

The register fields drive these outputs:
- a stop-mode request;
- the crystal pin-function select;
- the crystal drive-strength select;
- the low-speed oscillator stop;
- a crystal-output-high control.

The prescaler makes a one-cycle system clock enable every 1, 2, 4 or 16 source cycles. The two top register bits pick the ratio, but only while a sibling divider-override input is low. While that input is high, a fixed override ratio applies instead. A new ratio takes effect only at the end of the current prescaler period.

Top module: `sysclk_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x20, and sys_ce is high on every cycle (divide-by-1).
- R2: A write (wr_en high) changes the register only when prot_wen is high in the same cycle. Otherwise the register keeps its value.
- R3: Bits 2 and 1 always read 0, whatever value is written to them.
- R4: Bit 0 is the stop request (stop_req) and bit 3 the pin select (xtal_pin_sel, 1 = crystal pins). xout_high is 1 exactly when both bits are 1.
- R5: While csp_mode is high, accepted writes leave bits 0 and 4 unchanged. The other writable bits still update.
- R6: While osc_sel_onchip is 1, bit 4 (losc_stop) reads 0, and writing 1 to it has no effect.
- R7: When osc_sel_onchip falls from 1 to 0, bit 4 becomes 1 one cycle later. While it stays 0, bit 4 is writable.
- R8: An accepted write that sets bit 0 from 0 to 1 while hs_mode is 1 leaves bit 5 (xtal_drive_hi) at 1, whatever was written to bit 5.
- R9: With div_field_dis low, bits 7:6 give the sys_ce period: 00 gives 1 cycle, 01 gives 2, 10 gives 4 and 11 gives 16. Each pulse lasts one cycle.
- R10: With div_field_dis high, the sys_ce period is OVR_DIV (default 8) cycles whatever bits 7:6 hold.
- R11: A ratio change takes effect only at the next terminal count. Moving from divide-by-16 to divide-by-1 just after a pulse gives one more 16-cycle gap, then a pulse every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| prot_wen | input | 1 | Protect enable; writes land only while high |
| csp_mode | input | 1 | Count-source-protect mode; freezes bits 0 and 4 |
| osc_sel_onchip | input | 1 | 1 = on-chip oscillator selected, 0 = main clock selected |
| hs_mode | input | 1 | 1 while running in a high- or medium-speed mode |
| div_field_dis | input | 1 | Sibling override; 1 makes the prescaler ignore bits 7:6 |
| rd_data | output | 8 | Register read value |
| sys_ce | output | 1 | Prescaled system clock enable |
| stop_req | output | 1 | Stop-mode request (bit 0) |
| xtal_pin_sel | output | 1 | Crystal pin function select (bit 3) |
| xtal_drive_hi | output | 1 | Crystal drive strength high (bit 5) |
| losc_stop | output | 1 | Low-speed oscillator stop (bit 4) |
| xout_high | output | 1 | Drive crystal output pin high |

## Verification
A wrong register bit shows on rd_data, and on the output that bit drives, at the first sampling point after the write edge. So gating and forcing faults are seen one cycle after the stimulus. A wrong prescaler limit or counter shows up as a wrong gap between sys_ce pulses. This is visible within at most one old period plus one new period, which the bench measures for every ratio code and for the override. A ratio loaded at the wrong moment gives a first gap that is too short after a change.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  localparam logic [7:0] CFG_RESET = 8'h20;

  localparam int B_STOP   = 0;
  localparam int B_PINSEL = 3;
  localparam int B_LOSC   = 4;
  localparam int B_DRIVE  = 5;
  localparam int B_DIVLO  = 6;

  function automatic int div_ratio(input logic [1:0] code);
    int r;
    case (code)
      2'b00:   r = 1;
      2'b01:   r = 2;
      2'b10:   r = 4;
      default: r = 16;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sysclk_cfg_reg.sv
module sysclk_cfg_reg
  import sysclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       prot_wen,
  input  logic       csp_mode,
  input  logic       osc_sel_onchip,
  input  logic       hs_mode,
  output logic [7:0] cfg_q
);

  logic [7:0] cfg_d;
  logic       onchip_q;
  logic       wr_ok;
  logic       main_edge;
  logic       stop_entry;
  logic       unused_rsvd;

  assign unused_rsvd = ^wr_data[2:1];
  assign wr_ok       = wr_en & prot_wen;
  assign main_edge   = onchip_q & ~osc_sel_onchip;
  assign stop_entry  = wr_ok & ~csp_mode & wr_data[B_STOP] & ~cfg_q[B_STOP];

  always_comb begin
    cfg_d = cfg_q;
    if (wr_ok) begin
      cfg_d[7:6]      = wr_data[7:6];
      cfg_d[B_DRIVE]  = wr_data[B_DRIVE];
      cfg_d[B_PINSEL] = wr_data[B_PINSEL];
      if (!csp_mode) begin
        cfg_d[B_STOP] = wr_data[B_STOP];
        cfg_d[B_LOSC] = wr_data[B_LOSC];
      end
    end
    if (stop_entry && hs_mode) cfg_d[B_DRIVE] = 1'b1;
    if (main_edge)             cfg_d[B_LOSC]  = 1'b1;
    if (osc_sel_onchip)        cfg_d[B_LOSC]  = 1'b0;
    cfg_d[2:1] = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= CFG_RESET;
      onchip_q <= 1'b1;
    end else begin
      cfg_q    <= cfg_d;
      onchip_q <= osc_sel_onchip;
    end
  end

  AST_PROT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !prot_wen && osc_sel_onchip && onchip_q) |=> $stable(cfg_q)); // R2
  AST_CSP_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    csp_mode |=> $stable(cfg_q[B_STOP])); // R5
  AST_ONCHIP_LOSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    osc_sel_onchip |=> !cfg_q[B_LOSC]); // R6
  AST_MAIN_LOSC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (onchip_q && !osc_sel_onchip) |=> cfg_q[B_LOSC]); // R7
  AST_STOP_DRIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_q[B_STOP]) && $past(hs_mode)) |-> cfg_q[B_DRIVE]); // R8

endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler
  import sysclk_pkg::*;
#(
  parameter int MAX_DIV = 16,
  parameter int OVR_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div_code,
  input  logic       div_field_dis,
  output logic       sys_ce
);

  localparam int CNT_W = $clog2(MAX_DIV);
  localparam int GAP_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [CNT_W-1:0] lim_sel;
  logic             tc;
  int               ratio;

  always_comb begin
    ratio   = div_field_dis ? OVR_DIV : div_ratio(div_code);
    lim_sel = CNT_W'(ratio - 1);
  end

  assign tc     = (cnt_q == lim_q);
  assign sys_ce = tc;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    lim_d = lim_q;
    if (tc) begin
      cnt_d = '0;
      lim_d = lim_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gap_q <= '0;
    else if (sys_ce)                   gap_q <= '0;
    else if (gap_q != {GAP_W{1'b1}})   gap_q <= gap_q + 1'b1;
  end

  AST_CE_WITHIN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gap_q) < MAX_DIV); // R9

endmodule

// File: rtl/sysclk_ctrl_reg.sv
module sysclk_ctrl_reg
  import sysclk_pkg::*;
#(
  parameter int MAX_DIV = 16,
  parameter int OVR_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       prot_wen,
  input  logic       csp_mode,
  input  logic       osc_sel_onchip,
  input  logic       hs_mode,
  input  logic       div_field_dis,
  output logic [7:0] rd_data,
  output logic       sys_ce,
  output logic       stop_req,
  output logic       xtal_pin_sel,
  output logic       xtal_drive_hi,
  output logic       losc_stop,
  output logic       xout_high
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [7:0] cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sysclk_cfg_reg u_cfg (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .prot_wen       (prot_wen),
    .csp_mode       (csp_mode),
    .osc_sel_onchip (osc_sel_onchip),
    .hs_mode        (hs_mode),
    .cfg_q          (cfg)
  );

  sysclk_prescaler #(.MAX_DIV(MAX_DIV), .OVR_DIV(OVR_DIV)) u_pre (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .div_code      (cfg[B_DIVLO+1:B_DIVLO]),
    .div_field_dis (div_field_dis),
    .sys_ce        (sys_ce)
  );

  assign rd_data       = cfg;
  assign stop_req      = cfg[B_STOP];
  assign xtal_pin_sel  = cfg[B_PINSEL];
  assign xtal_drive_hi = cfg[B_DRIVE];
  assign losc_stop     = cfg[B_LOSC];
  assign xout_high     = cfg[B_STOP] & cfg[B_PINSEL];

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_data[2:1] == 2'b00); // R3
  AST_XOUT_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_int_n)
    xout_high |-> (stop_req && xtal_pin_sel)); // R4

endmodule

// File: tb/sysclk_ctrl_reg_bench.sv
module sysclk_ctrl_reg_bench;

  logic       clk = 1'b0;
  logic       rst_n, wr_en, prot_wen, csp_mode, osc_sel_onchip, hs_mode, div_field_dis;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       sys_ce, stop_req, xtal_pin_sel, xtal_drive_hi, losc_stop, xout_high;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sysclk_ctrl_reg u_sysclk_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .prot_wen(prot_wen), .csp_mode(csp_mode), .osc_sel_onchip(osc_sel_onchip),
    .hs_mode(hs_mode), .div_field_dis(div_field_dis), .rd_data(rd_data),
    .sys_ce(sys_ce), .stop_req(stop_req), .xtal_pin_sel(xtal_pin_sel),
    .xtal_drive_hi(xtal_drive_hi), .losc_stop(losc_stop), .xout_high(xout_high)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic p);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; prot_wen = p;
    @(negedge clk);
    wr_en = 1'b0; prot_wen = 1'b0;
  endtask

  task automatic wait_ce(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sys_ce && n < 40);
  endtask

  task automatic run_tests();
    int n;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; prot_wen = 1'b0; csp_mode = 1'b0;
    osc_sel_onchip = 1'b1; hs_mode = 1'b0; div_field_dis = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h20);
    chk("R1 outputs", {stop_req, xtal_pin_sel, xtal_drive_hi, losc_stop, xout_high}, 5'b00100);
    chk("R1 sys_ce", sys_ce, 1);
    @(negedge clk);
    chk("R1 sys_ce next", sys_ce, 1);
    // R2 write dropped without protect enable
    wr(8'hFF, 1'b0);
    chk("R2 blocked", rd_data, 8'h20);
    // R2 R3 accepted write, reserved bits read 0, bit4 forced 0 (R6)
    wr(8'h8E, 1'b1);
    chk("R3 rsvd zero", rd_data, 8'h88);
    // R4 stop plus pins
    wr(8'h89, 1'b1);
    chk("R4 rd", rd_data, 8'h89);
    chk("R4 stop/xout", {stop_req, xtal_pin_sel, xout_high}, 3'b111);
    wr(8'h88, 1'b1);
    chk("R4 xout low", xout_high, 0);
    wr(8'h80, 1'b1);
    chk("R4 pin gp", {xtal_pin_sel, xout_high}, 2'b00);
    // R8 stop entry from fast mode forces drive high
    hs_mode = 1'b1;
    wr(8'h09, 1'b1);
    chk("R8 drive forced", rd_data, 8'h29);
    wr(8'h00, 1'b1);
    chk("R8 no entry", rd_data, 8'h00);
    hs_mode = 1'b0;
    // R7 main clock selected sets bit4
    @(negedge clk); osc_sel_onchip = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 losc set", rd_data, 8'h10);
    wr(8'h00, 1'b1);
    chk("R7 writable", losc_stop, 0);
    // R5 freeze
    csp_mode = 1'b1;
    wr(8'h11, 1'b1);
    chk("R5 frozen", rd_data, 8'h00);
    wr(8'h09, 1'b1);
    chk("R5 others write", rd_data, 8'h08);
    csp_mode = 1'b0;
    wr(8'h10, 1'b1);
    chk("R5 after csp", rd_data, 8'h10);
    // R6 on-chip forces bit4 low, write of 1 ignored
    @(negedge clk); osc_sel_onchip = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 forced low", losc_stop, 0);
    wr(8'h10, 1'b1);
    chk("R6 write ignored", rd_data, 8'h00);
    // R9 R10 prescaler sweep
    for (int dis = 0; dis < 2; dis++) begin
      for (int code = 0; code < 4; code++) begin
        int expn;
        div_field_dis = dis[0];
        wr({code[1:0], 6'b000000}, 1'b1);
        wait_ce(n);
        wait_ce(n);
        expn = dis ? 8 : (code == 3 ? 16 : (1 << code));
        chk(dis ? "R10 period" : "R9 period", n, expn);
        if (expn > 1) begin
          @(negedge clk);
          chk("R9 one-cycle pulse", sys_ce, 0);
        end
      end
    end
    div_field_dis = 1'b0;
    // R11 change applies at next terminal count
    wr(8'hC0, 1'b1);
    wait_ce(n);
    wait_ce(n);
    wr_en = 1'b1; wr_data = 8'h00; prot_wen = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      wr_en = 1'b0; prot_wen = 1'b0;
      n++;
    end while (!sys_ce && n < 40);
    chk("R11 old gap kept", n, 16);
    wait_ce(n);
    chk("R11 new ratio", n, 1);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule